// File: doc/BRIEF.md
# Masked-Search Binary CAM

This block is a binary content-addressable memory built from flip-flops. By default it holds 256 rows of 15 bits. A single mode input chooses what each cycle does. In write mode, the word on the write-data input is stored at the row given by the address, and that row becomes valid. In every other cycle a search runs. All rows are compared at once against a search argument. A per-bit mask picks which argument bits take part in the compare.

Each search produces three registered results. The first is a vector with one flag per row that matched. The second is the encoded address of the lowest-numbered matching row. The third is a single hit flag that says whether any row matched. Reset marks every row invalid. Because an invalid row never matches, software fills the table through the write port before it relies on search results. A typical use is looking up a connectivity record (a gate's operands, output and type) by any chosen subset of its fields.

Top module: `mbcam_top`

## Requirements
- R1: A write cycle (`wr_sel`=1) stores `wdata` into row `addr` and marks it valid. A later write to the same row replaces the old word completely.
- R2: Mask bit `srch_mask[b]`=1 means bit b of the argument is compared. Mask bit 0 means bit b is ignored. A mask of all ones compares the whole word, and a mask of all zeros matches every valid row.
- R3: `match_vec[r]` is 1 exactly when row r is valid and agrees with `srch_arg` on every masked bit.
- R4: After reset no row is valid, and an invalid row never sets its flag.
- R5: `hit` is 1 exactly when at least one flag of `match_vec` is 1.
- R6: `hit_addr` is the lowest index r with `match_vec[r]`=1. It is 0 when nothing matches.
- R7: A search applied in a cycle (`wr_sel`=0) shows its results on the outputs just after the clock edge that ends that cycle.
- R8: A write cycle performs no search. All three outputs keep their previous values across it.
- R9: While reset (`rst_n`=0) is asserted, `match_vec`, `hit_addr` and `hit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_sel | input | 1 | 1 = write cycle, 0 = search cycle |
| addr | input | 8 | Row written in a write cycle |
| wdata | input | 15 | Word written in a write cycle |
| srch_arg | input | 15 | Search argument |
| srch_mask | input | 15 | Compare mask, 1 = bit is compared |
| match_vec | output | 256 | Registered per-row match flags |
| hit_addr | output | 8 | Registered lowest matching row index |
| hit | output | 1 | Registered any-row-matched flag |

## Verification
The hardest case to reach from the ports is a search where several rows match at once. The lowest one must win the encoded address, and a row at the top boundary must be reported when it is the only match. Random writes draw from a pool of four words that differ in only a few bits, and random masks are biased to clear those bits. Most searches therefore hit many scattered rows at once. Directed steps place a unique word in row 255, overwrite it, and use all-zero and single-bit masks to cover the priority and masking edges.

// File: rtl/mbcam_pkg.sv
package mbcam_pkg;
   typedef enum logic {
      OP_SEARCH = 1'b0,
      OP_WRITE  = 1'b1
   } cam_op_e;
endpackage

// File: rtl/mbcam_row.sv
module mbcam_row #(
   parameter int WIDTH = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] arg,
   input  logic [WIDTH-1:0] mask,
   output logic             match
);
   logic [WIDTH-1:0] word_q;
   logic             valid_q;
   logic [WIDTH-1:0] bit_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  valid_q <= 1'b0;
      else if (we) valid_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we) word_q <= wdata;
   end

   // one comparator per stored bit
   for (genvar b = 0; b < WIDTH; b++) begin : g_cell
      assign bit_ok[b] = ~mask[b] | (word_q[b] ~^ arg[b]);
   end

   assign match = valid_q & (&bit_ok);
endmodule

// File: rtl/mbcam_prienc.sv
module mbcam_prienc #(
   parameter int N  = 256,
   parameter int AW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [AW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = AW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/mbcam_top.sv
module mbcam_top #(
   parameter int ROWS  = 256,
   parameter int WIDTH = 15,
   parameter int AW    = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] srch_arg,
   input  logic [WIDTH-1:0] srch_mask,
   output logic [ROWS-1:0]  match_vec,
   output logic [AW-1:0]    hit_addr,
   output logic             hit
);
   import mbcam_pkg::*;

   localparam int MIN_AW = (ROWS > 1) ? $clog2(ROWS) : 1;

   if (ROWS < 2) begin : g_bad_rows
      $error("mbcam_top: ROWS must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mbcam_top: WIDTH must be at least 1");
   end
   if (AW < MIN_AW) begin : g_bad_aw
      $error("mbcam_top: AW too narrow for ROWS");
   end

   cam_op_e         op;
   logic [ROWS-1:0] row_we;
   logic [ROWS-1:0] row_match;
   logic [AW-1:0]   enc_idx;
   logic            enc_any;

   assign op = cam_op_e'(wr_sel);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_we[r] = (op == OP_WRITE) && (addr == AW'(r));
      mbcam_row #(.WIDTH(WIDTH)) row_i (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (row_we[r]),
         .wdata (wdata),
         .arg   (srch_arg),
         .mask  (srch_mask),
         .match (row_match[r])
      );
   end

   mbcam_prienc #(.N(ROWS), .AW(AW)) enc_i (
      .vec (row_match),
      .idx (enc_idx),
      .any (enc_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_vec <= '0;
         hit_addr  <= '0;
         hit       <= 1'b0;
      end else if (op == OP_SEARCH) begin
         match_vec <= row_match;
         hit_addr  <= enc_idx;
         hit       <= enc_any;
      end
   end

   // R5: hit flag agrees with the registered flag vector
   p_hit_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit == (|match_vec));

   // R6: reported address points at a set flag
   p_addr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> match_vec[hit_addr]);

   // R6: no lower-numbered row matched
   p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((match_vec & ((ROWS'(1) << hit_addr) - ROWS'(1))) == '0));

   // R6: address is zero on a miss
   p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_addr == '0));

   // R8: outputs hold across a write cycle
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> ($stable(match_vec) && $stable(hit_addr) && $stable(hit)));
endmodule

// File: tb/mbcam_top_tb_top.sv
module mbcam_top_tb_top;
   localparam int ROWS = 256;
   localparam int W    = 15;
   localparam int AW   = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_sel = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [W-1:0]    wdata = '0;
   logic [W-1:0]    srch_arg = '0;
   logic [W-1:0]    srch_mask = '0;
   logic [ROWS-1:0] match_vec;
   logic [AW-1:0]   hit_addr;
   logic            hit;

   int n_chk = 0;
   int n_bad = 0;

   logic [W-1:0]    m_word [ROWS];
   logic            m_val  [ROWS];
   logic [ROWS-1:0] e_vec;
   logic [AW-1:0]   e_addr;
   logic            e_hit;
   logic [W-1:0]    pool [4];

   always #10 clk = ~clk;   // 50 MHz

   mbcam_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .addr(addr), .wdata(wdata),
      .srch_arg(srch_arg), .srch_mask(srch_mask),
      .match_vec(match_vec), .hit_addr(hit_addr), .hit(hit)
   );

   function automatic logic [ROWS-1:0] model_vec(logic [W-1:0] a, logic [W-1:0] k);
      logic [ROWS-1:0] v = '0;
      for (int r = 0; r < ROWS; r++)
         v[r] = m_val[r] && (((m_word[r] ^ a) & k) == '0);
      return v;
   endfunction

   function automatic logic [AW-1:0] model_low(logic [ROWS-1:0] v);
      for (int r = 0; r < ROWS; r++)
         if (v[r]) return AW'(r);
      return '0;
   endfunction

   task automatic check(string tag);
      n_chk++;
      if (match_vec !== e_vec || hit !== e_hit || hit_addr !== e_addr) begin
         n_bad++;
         $display("FAIL %s: vec=%h hit=%0b addr=%0d expected vec=%h hit=%0b addr=%0d",
                  tag, match_vec, hit, hit_addr, e_vec, e_hit, e_addr);
      end
   endtask

   // write cycle: results must not move (R8); model updated for R1
   task automatic do_write(logic [AW-1:0] a, logic [W-1:0] d);
      wr_sel = 1'b1; addr = a; wdata = d;
      srch_arg = W'($urandom); srch_mask = W'($urandom);
      m_word[a] = d; m_val[a] = 1'b1;
      @(negedge clk);
      check("R8 write holds outputs");
   endtask

   // search cycle: results visible after the closing edge (R7)
   task automatic do_search(logic [W-1:0] a, logic [W-1:0] k, string tag);
      wr_sel = 1'b0; srch_arg = a; srch_mask = k;
      e_vec = model_vec(a, k); e_hit = |e_vec; e_addr = model_low(e_vec);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      pool[0] = 15'h0011; pool[1] = 15'h0013; pool[2] = 15'h4011; pool[3] = 15'h4033;
      for (int r = 0; r < ROWS; r++) begin m_word[r] = '0; m_val[r] = 1'b0; end
      e_vec = '0; e_hit = 1'b0; e_addr = '0;

      // R9: outputs are zero while reset is held, even with search stimulus
      srch_mask = '0;
      repeat (3) @(negedge clk);
      check("R9 reset state");
      rst_n = 1'b1;

      // R4: no valid rows, all-zero mask still matches nothing
      do_search('0, '0, "R4 empty table never matches");
      do_search(15'h7FFF, 15'h7FFF, "R4 empty table full mask");

      // R1/R6: unique word in top row, sole match at boundary address
      do_write(8'd255, 15'h2AAA);
      do_search(15'h2AAA, 15'h7FFF, "R1 R6 top row sole hit");
      // R2: a differing bit that is masked off is ignored
      do_search(15'h2AAB, 15'h7FFE, "R2 masked bit ignored");
      do_search(15'h2AAB, 15'h7FFF, "R2 full mask sees difference");
      // R1: overwrite replaces the old word
      do_write(8'd255, 15'h1555);
      do_search(15'h2AAA, 15'h7FFF, "R1 old word gone after overwrite");
      do_search(15'h1555, 15'h7FFF, "R1 new word found");
      // R6: lower row wins when both match
      do_write(8'd7, 15'h1555);
      do_search(15'h1555, 15'h7FFF, "R6 lowest row wins");
      do_write(8'd0, 15'h0000);
      do_search('0, '0, "R2 zero mask matches all valid rows");
      do_search(15'h0001, 15'h0001, "R2 single-bit mask");

      // random mix (R3 R5 R6 R7 R8)
      for (int i = 0; i < 1500; i++) begin
         if ($urandom_range(0, 2) == 0) begin
            do_write(AW'($urandom), pool[$urandom_range(0, 3)]);
         end else begin
            logic [W-1:0] k;
            k = ($urandom_range(0, 3) == 0) ? 15'h7FFF : (W'($urandom) & 15'h3FDD) | 15'h0011;
            do_search(pool[$urandom_range(0, 3)] ^ (($urandom_range(0, 7) == 0) ? 15'h0100 : 15'h0),
                      k, "R3 R5 R6 R7 random search");
         end
      end
      do_search(pool[0], 15'h0011, "R3 broad multi-match");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule